// File: doc/BRIEF.md
# Clocked-Mode Serial Frame Engine

This block is the shifting core of a serial port that runs with a shared bit clock (XCK) instead of oversampling. It holds a transmitter and a receiver. The transmitter takes a parallel character through a valid/ready handshake and shifts it onto `txd`. The receiver watches `rxd`, rebuilds the character and reports parity and framing problems. The frame shape is set at run time through three configuration inputs: the character length (5 to 9 bits), the parity mode and the stop-bit count. Each side latches the format when a frame begins. A length value outside 5..9 is clamped into that range.

XCK is brought into the system clock domain through a synchronizer and then edge-detected. A polarity input decides which XCK edge drives new transmit data and which edge samples receive data. The two are always opposite edges, so a loopback from `txd` to `rxd` has half an XCK period of margin. All state changes happen on system-clock cycles that carry the selected edge strobe.

Top module: `usart_sync_frame`

## Requirements
- R1: A frame on `txd` is one start bit at 0, then the data bits with bit 0 first, then the parity bit if enabled, then the stop bits at 1. When nothing is queued, `txd` stays at 1.
- R2: `cfg_len` sets the number of data bits (5, 6, 7, 8 or 9). Character bits at or above that length are not transmitted.
- R3: `cfg_par` encodes 0 = no parity, 1 = even, 2 = odd (3 acts as none). Even parity makes the XOR of the data bits and the parity bit 0. Odd parity makes it 1.
- R4: `cfg_stop2` = 0 gives one stop bit and 1 gives two stop bits.
- R5: With `pol` = 0, `txd` changes only after a rising XCK edge and `rxd` is sampled at a falling edge. With `pol` = 1 the two edges swap.
- R6: A character is taken when `tx_valid` and `tx_ready` are both high. `tx_ready` is high only when no character is waiting and the transmitter is idle or in its final stop bit. A character taken during the final stop bit starts at the next drive edge, with no idle bit in between.
- R7: After the receiver samples the first stop bit, it raises `rx_valid` for exactly one cycle. At the same time it presents the character on `rx_data`, with bits at and above the configured length set to 0.
- R8: `rx_perr` is raised with `rx_valid` when the received parity bit breaks the configured rule. It is always 0 when parity is off.
- R9: `rx_ferr` is raised with `rx_valid` when the first stop bit is sampled as 0. A second stop bit is never checked.
- R10: After reset, `txd` = 1, `tx_ready` = 1, `rx_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| xck | input | 1 | Serial bit clock, asynchronous to clk |
| pol | input | 1 | Edge select: 0 = drive on rise, sample on fall; 1 = swapped |
| cfg_len | input | 4 | Data bits per character, 5..9 |
| cfg_par | input | 2 | Parity mode: 0 none, 1 even, 2 odd |
| cfg_stop2 | input | 1 | 1 selects two stop bits |
| tx_valid | input | 1 | Character offered for transmission |
| tx_data | input | 9 | Character to transmit |
| tx_ready | output | 1 | Transmitter can take a character |
| txd | output | 1 | Serial data out |
| rxd | input | 1 | Serial data in |
| rx_valid | output | 1 | One-cycle pulse, received character present |
| rx_data | output | 9 | Received character, zero-extended |
| rx_perr | output | 1 | Parity error for the presented character |
| rx_ferr | output | 1 | Framing error for the presented character |

## Verification
Two actions can fall in the same cycle. In the final stop bit, the transmitter takes the next character and then launches its start bit. Meanwhile, through a loopback, the receiver is finishing the previous frame and must treat the very next sample as a new start bit. The bench provokes this by queuing three characters back to back with `txd` looped to `rxd`, under random formats and both polarities. It passes only if the captured line matches the concatenated expected frames with no idle bit between them, and all three characters arrive intact with clean flags. Capturing `txd` just before the sampling edge, and changing `rxd` only after the drive edge, makes any mix-up of the two edges visible.

// File: rtl/usart_sync_pkg.sv
package usart_sync_pkg;

    localparam int DW      = 9;
    localparam int CNT_W   = 4;
    localparam int MIN_LEN = 5;
    localparam int MAX_LEN = DW;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_EVEN = 2'd1,
        PAR_ODD  = 2'd2,
        PAR_RSVD = 2'd3
    } par_mode_e;

    typedef struct packed {
        logic [CNT_W-1:0] len;
        par_mode_e        par;
        logic             stop2;
    } frame_cfg_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PAR,
        PH_STOP1,
        PH_STOP2
    } phase_e;

    function automatic logic [CNT_W-1:0] clamp_len(input logic [CNT_W-1:0] l);
        if (l < CNT_W'(MIN_LEN)) return CNT_W'(MIN_LEN);
        if (l > CNT_W'(MAX_LEN)) return CNT_W'(MAX_LEN);
        return l;
    endfunction

    function automatic logic [DW-1:0] len_mask(input logic [CNT_W-1:0] l);
        return DW'((32'd1 << l) - 32'd1);
    endfunction

    function automatic logic par_enabled(input par_mode_e p);
        return (p == PAR_EVEN) || (p == PAR_ODD);
    endfunction

    // Bit that completes the parity rule for the character under the mask
    function automatic logic par_fill(input logic [DW-1:0] d, input logic [CNT_W-1:0] l,
                                      input par_mode_e p);
        return (^(d & len_mask(l))) ^ (p == PAR_ODD);
    endfunction

endpackage

// File: rtl/usart_xck_edge.sv
module usart_xck_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic xck,
    input  logic pol,
    output logic launch_stb,
    output logic sample_stb
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] sh;
    logic            rise, fall;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[SH_W-2:0], xck};
    end

    assign rise = sh[SH_W-2] & ~sh[SH_W-1];
    assign fall = ~sh[SH_W-2] & sh[SH_W-1];

    assign launch_stb = pol ? fall : rise;
    assign sample_stb = pol ? rise : fall;
endmodule

// File: rtl/usart_sync_tx.sv
module usart_sync_tx
    import usart_sync_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          launch_stb,
    input  frame_cfg_t    cfg,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          in_ready,
    output logic          txd
);
    phase_e           phase;
    frame_cfg_t       cfg_q;
    logic [DW-1:0]    shreg;
    logic [CNT_W-1:0] cnt;
    logic             pbit;
    logic             pend;
    logic [DW-1:0]    pend_data;
    logic             final_stop, wrap;

    assign final_stop = (phase == PH_STOP2) || (phase == PH_STOP1 && !cfg_q.stop2);
    assign wrap       = (phase == PH_IDLE) || final_stop;
    assign in_ready   = !pend && wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            cfg_q     <= '0;
            shreg     <= '0;
            cnt       <= '0;
            pbit      <= 1'b0;
            pend      <= 1'b0;
            pend_data <= '0;
            txd       <= 1'b1;
        end else begin
            if (launch_stb) begin
                if (wrap) begin
                    if (pend) begin
                        txd       <= 1'b0;
                        phase     <= PH_START;
                        shreg     <= pend_data;
                        cfg_q     <= '{len: clamp_len(cfg.len), par: cfg.par, stop2: cfg.stop2};
                        pbit      <= par_fill(pend_data, clamp_len(cfg.len), cfg.par);
                        pend      <= 1'b0;
                    end else begin
                        txd       <= 1'b1;
                        phase     <= PH_IDLE;
                    end
                end else begin
                    case (phase)
                        PH_START: begin
                            txd   <= shreg[0];
                            shreg <= shreg >> 1;
                            cnt   <= CNT_W'(1);
                            phase <= PH_DATA;
                        end
                        PH_DATA: begin
                            if (cnt == cfg_q.len) begin
                                if (par_enabled(cfg_q.par)) begin
                                    txd   <= pbit;
                                    phase <= PH_PAR;
                                end else begin
                                    txd   <= 1'b1;
                                    phase <= PH_STOP1;
                                end
                            end else begin
                                txd   <= shreg[0];
                                shreg <= shreg >> 1;
                                cnt   <= cnt + 1'b1;
                            end
                        end
                        PH_PAR: begin
                            txd   <= 1'b1;
                            phase <= PH_STOP1;
                        end
                        PH_STOP1: begin
                            txd   <= 1'b1;
                            phase <= PH_STOP2;
                        end
                        default: begin
                            txd   <= 1'b1;
                            phase <= PH_IDLE;
                        end
                    endcase
                end
            end
            if (in_valid && in_ready) begin
                pend      <= 1'b1;
                pend_data <= in_data;
            end
        end
    end

    // R5
    txd_launch_only_chk: assert property (@(posedge clk) disable iff (rst)
        !launch_stb |=> $stable(txd));

    // R6
    take_closes_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);
endmodule

// File: rtl/usart_sync_rx.sv
module usart_sync_rx
    import usart_sync_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          sample_stb,
    input  frame_cfg_t    cfg,
    input  logic          rxd,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          out_perr,
    output logic          out_ferr
);
    phase_e           phase;
    frame_cfg_t       cfg_q;
    logic [DW-1:0]    shreg;
    logic [CNT_W-1:0] cnt, cnt_inc;
    logic             pbit_q;

    assign cnt_inc = cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            cfg_q     <= '0;
            shreg     <= '0;
            cnt       <= '0;
            pbit_q    <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_perr  <= 1'b0;
            out_ferr  <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (sample_stb) begin
                case (phase)
                    PH_IDLE: begin
                        if (!rxd) begin
                            phase <= PH_DATA;
                            cfg_q <= '{len: clamp_len(cfg.len), par: cfg.par, stop2: cfg.stop2};
                            cnt   <= '0;
                            shreg <= '0;
                        end
                    end
                    PH_DATA: begin
                        shreg <= shreg | (DW'(rxd) << cnt);
                        cnt   <= cnt_inc;
                        if (cnt_inc == cfg_q.len)
                            phase <= par_enabled(cfg_q.par) ? PH_PAR : PH_STOP1;
                    end
                    PH_PAR: begin
                        pbit_q <= rxd;
                        phase  <= PH_STOP1;
                    end
                    default: begin
                        out_valid <= 1'b1;
                        out_data  <= shreg;
                        out_ferr  <= !rxd;
                        out_perr  <= par_enabled(cfg_q.par) &&
                                     (par_fill(shreg, cfg_q.len, cfg_q.par) != pbit_q);
                        phase     <= PH_IDLE;
                    end
                endcase
            end
        end
    end

    // R7
    rx_pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R7
    rx_zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_data & ~len_mask(cfg_q.len)) == '0));

    // R8
    rx_no_perr_off_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !par_enabled(cfg_q.par)) |-> !out_perr);

    // R5
    rx_on_sample_chk: assert property (@(posedge clk) disable iff (rst)
        !sample_stb |=> !out_valid);
endmodule

// File: rtl/usart_sync_frame.sv
module usart_sync_frame
    import usart_sync_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          xck,
    input  logic          pol,
    input  logic [3:0]    cfg_len,
    input  logic [1:0]    cfg_par,
    input  logic          cfg_stop2,
    input  logic          tx_valid,
    input  logic [8:0]    tx_data,
    output logic          tx_ready,
    output logic          txd,
    input  logic          rxd,
    output logic          rx_valid,
    output logic [8:0]    rx_data,
    output logic          rx_perr,
    output logic          rx_ferr
);
    logic       launch_stb, sample_stb;
    frame_cfg_t cfg;

    assign cfg = '{len: cfg_len, par: par_mode_e'(cfg_par), stop2: cfg_stop2};

    usart_xck_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst(rst), .xck(xck), .pol(pol),
        .launch_stb(launch_stb), .sample_stb(sample_stb)
    );

    usart_sync_tx u_tx (
        .clk(clk), .rst(rst), .launch_stb(launch_stb), .cfg(cfg),
        .in_valid(tx_valid), .in_data(tx_data), .in_ready(tx_ready), .txd(txd)
    );

    usart_sync_rx u_rx (
        .clk(clk), .rst(rst), .sample_stb(sample_stb), .cfg(cfg), .rxd(rxd),
        .out_valid(rx_valid), .out_data(rx_data), .out_perr(rx_perr), .out_ferr(rx_ferr)
    );

    // R5
    edges_apart_chk: assert property (@(posedge clk) disable iff (rst)
        !(launch_stb && sample_stb));
endmodule

// File: tb/usart_sync_frame_tb.sv
module usart_sync_frame_tb;
    logic clk = 1'b0, rst = 1'b1, xck = 1'b0, pol = 1'b0;
    logic [3:0] cfg_len = 4'd8;
    logic [1:0] cfg_par = 2'd0;
    logic cfg_stop2 = 1'b0;
    logic tx_valid, tx_ready, txd, rxd, rx_valid, rx_perr, rx_ferr;
    logic [8:0] tx_data, rx_data;
    logic loop_en = 1'b0, rxd_drv = 1'b1, tb_clr = 1'b0;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic [8:0] tx_chars [0:3];
    int tx_cnt = 0, tx_idx = 0;
    logic [8:0] got_d [0:7];
    logic got_p [0:7], got_f [0:7];
    int rx_n = 0;
    logic [63:0] exp_v, mid_v, end_v;

    assign rxd      = loop_en ? txd : rxd_drv;
    assign tx_valid = (tx_idx < tx_cnt);
    assign tx_data  = tx_chars[tx_idx[1:0]];

    always #2 clk = ~clk;

    usart_sync_frame u_dut (
        .clk(clk), .rst(rst), .xck(xck), .pol(pol), .cfg_len(cfg_len), .cfg_par(cfg_par),
        .cfg_stop2(cfg_stop2), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .txd(txd), .rxd(rxd), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr)
    );

    always @(posedge clk) begin
        if (tb_clr) tx_idx <= 0;
        else if (tx_valid && tx_ready) tx_idx <= tx_idx + 1;
    end

    always @(posedge clk) begin
        if (tb_clr) rx_n <= 0;
        else if (rx_valid) begin
            if (rx_n < 8) begin
                got_d[rx_n] <= rx_data;
                got_p[rx_n] <= rx_perr;
                got_f[rx_n] <= rx_ferr;
            end
            rx_n <= rx_n + 1;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] mask_of(input int len);
        return 9'((1 << len) - 1);
    endfunction

    // kind: 0 clean, 1 parity flipped, 2 first stop low, 3 second stop low
    task automatic build_frame(input logic [8:0] d, input int len, input int par, input bit s2,
                               input int kind, inout int pos);
        int ones = 0;
        exp_v[pos] = 1'b0; pos++;
        for (int i = 0; i < len; i++) begin
            exp_v[pos] = d[i]; ones += d[i]; pos++;
        end
        if (par == 1 || par == 2) begin
            exp_v[pos] = ((ones % 2) == 1) ^ (par == 2) ^ (kind == 1); pos++;
        end
        exp_v[pos] = (kind != 2); pos++;
        if (s2) begin exp_v[pos] = (kind != 3); pos++; end
    endtask

    task automatic xck_bit(input logic rb, output logic tm, output logic te);
        @(negedge clk) xck = ~pol;
        repeat (4) @(negedge clk);
        rxd_drv = rb;
        repeat (3) @(negedge clk);
        tm = txd;
        @(negedge clk) xck = pol;
        repeat (7) @(negedge clk);
        te = txd;
    endtask

    task automatic run(input int nch, input bit lp, input int len, input int par,
                       input bit s2, input int kind);
        int pos = 0;
        int total;
        logic m, e;
        exp_v = '1; mid_v = '1; end_v = '1;
        for (int i = 0; i < nch; i++) build_frame(tx_chars[i], len, par, s2, kind, pos);
        total = pos + 14;
        cfg_len = 4'(len); cfg_par = 2'(par); cfg_stop2 = s2; loop_en = lp;
        @(negedge clk) tb_clr = 1'b1;
        @(negedge clk) tb_clr = 1'b0;
        tx_cnt = lp ? nch : 0;
        repeat (6) @(negedge clk);
        for (int b = 0; b < total; b++) begin
            xck_bit(lp ? 1'b1 : exp_v[b], m, e);
            mid_v[b] = m; end_v[b] = e;
        end
        repeat (4) @(negedge clk);
        tx_cnt = 0;
    endtask

    task automatic loop_case(input int nch, input string tag);
        int len = 5 + int'($urandom % 5);
        int par = int'($urandom % 3);
        bit s2 = bit'($urandom % 2);
        for (int i = 0; i < nch; i++) tx_chars[i] = 9'($urandom);
        run(nch, 1'b1, len, par, s2, 0);
        check({tag, " R1 R2 R3 R4 line at drive edge"}, end_v, exp_v);
        check({tag, " R5 line settled before sample edge"}, mid_v, exp_v);
        check({tag, " R7 character count"}, 64'(rx_n), 64'(nch));
        for (int i = 0; i < nch && i < 8; i++) begin
            check({tag, " R7 received data"}, 64'(got_d[i]), 64'(tx_chars[i] & mask_of(len)));
            check({tag, " R8 parity flag clean"}, 64'(got_p[i]), 64'd0);
            check({tag, " R9 framing flag clean"}, 64'(got_f[i]), 64'd0);
        end
    endtask

    task automatic rx_case(input int kind);
        int len = 5 + int'($urandom % 5);
        int par = (kind == 1) ? 1 + int'($urandom % 2) : int'($urandom % 3);
        bit s2 = (kind == 3) ? 1'b1 : bit'($urandom % 2);
        tx_chars[0] = 9'($urandom);
        run(1, 1'b0, len, par, s2, kind);
        check("R7 receive event seen", 64'(rx_n >= 1), 64'd1);
        check("R7 directed receive data", 64'(got_d[0]), 64'(tx_chars[0] & mask_of(len)));
        check("R8 parity flag", 64'(got_p[0]), 64'(kind == 1));
        check("R9 framing flag, first stop only", 64'(got_f[0]), 64'(kind == 2));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10
        check("R10 txd idle after reset", 64'(txd), 64'd1);
        check("R10 ready after reset", 64'(tx_ready), 64'd1);
        check("R10 no receive pulse after reset", 64'(rx_valid), 64'd0);

        for (int p = 0; p < 2; p++) begin
            pol = p[0];
            xck = pol;
            repeat (10) @(negedge clk);
            for (int k = 0; k < 10; k++) loop_case(1, "single");
            // R6 back-to-back frames
            loop_case(3, "R6 back-to-back");
            loop_case(3, "R6 back-to-back");
            for (int k = 0; k < 8; k++) rx_case(k % 4);
            check("R1 txd idle between tests", 64'(txd), 64'd1);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule